// File: doc/BRIEF.md
# Two-level page translation walker

The walker turns 32-bit virtual addresses into physical addresses. When paging is off, an address goes through unchanged. When paging is on, the block first looks in a four-entry translation cache. On a miss it reads a directory entry, then a second-level table entry, from memory through a single-outstanding read port. It checks the present, writable and user bits and returns either a physical address or a fault with a cause code.

The root register holds the page frame of the directory. Software loads it through a write strobe. Every load empties the translation cache, whether or not the value changes.

A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The block gives exactly one single-cycle `rsp_valid` pulse for each accepted request.

Top module: `vm_walker`

## Requirements
- R1: With `paging_en` low at acceptance, `rsp_valid` rises in the next cycle with `rsp_paddr` equal to the virtual address, no fault, and no memory fetch.
- R2: A fault-free translation returns `rsp_paddr` = {frame number, virtual bits [11:0]}. A table entry holds the frame number in bits [31:12], present in bit 0, writable in bit 1 and user in bit 2.
- R3: A walk first fetches the directory entry at {root frame, va[31:22], 2'b00}. It then fetches the table entry at {directory entry frame, va[21:12], 2'b00}.
- R4: A directory entry with present = 0 faults with kind 01 and no table fetch is made. A table entry with present = 0 also faults with kind 01.
- R5: For a user access, the effective user permission is the AND of the user bits at both levels. If it is 0, the access faults with kind 10.
- R6: For a write, the effective writable permission is the AND of the writable bits at both levels. If it is 0, the write faults with kind 11. When several checks fail, the priority is not-present, then user, then write. `rsp_cause` = {user access, write access, kind}, and kind 00 means no fault.
- R7: On a cache hit the response comes in the cycle after acceptance, with no memory fetch. The cached permissions are still checked.
- R8: Only fault-free walks are cached. Four entries are filled in rotating order, so each fill overwrites the slot after the previous fill.
- R9: A root write flushes every cached translation, even when the written value equals the current one.
- R10: A walk that sees a root write while it is in progress still returns its result, but that result is not cached.
- R11: `req_ready` is low from acceptance of a missing request until its response. `mem_req_valid` is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled at acceptance |
| root_we | input | 1 | Root register write strobe; flushes the cache |
| root_wdata | input | 32 | New root; bits [31:12] give the directory frame |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 4 | {user, write, kind[1:0]} |
| mem_req_valid | output | 1 | Entry fetch request, held until answered |
| mem_req_addr | output | 32 | Byte address of the entry fetched |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry data |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 12-bit page offset and four cache entries. It pairs the walker with a memory that answers two cycles after each fetch starts. This fixes the latencies at one cycle for hits and pass-through, three cycles for a missing directory entry and six cycles for a full walk. The bench compares `rsp_valid` and `req_ready` against these latencies on every clock. With only four slots, a fifth distinct page forces a replacement, so the rotating eviction and the later re-walk of an evicted page can both be observed.

// File: rtl/vmw_pkg.sv
package vmw_pkg;
    // bit positions inside a table entry
    localparam int unsigned ENT_P = 0;
    localparam int unsigned ENT_W = 1;
    localparam int unsigned ENT_U = 2;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_ABSENT = 2'd1,
        FK_USER   = 2'd2,
        FK_WRITE  = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_DIR  = 2'd1,
        WS_TBL  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/vmw_perm.sv
module vmw_perm
    import vmw_pkg::*;
(
    input  logic        present_i,
    input  logic        wr_ok_i,
    input  logic        usr_ok_i,
    input  logic        is_write_i,
    input  logic        is_user_i,
    output logic        fault_o,
    output fault_kind_e kind_o
);
    // priority: absent, then user, then write
    always_comb begin
        if (!present_i)                   kind_o = FK_ABSENT;
        else if (is_user_i && !usr_ok_i)  kind_o = FK_USER;
        else if (is_write_i && !wr_ok_i)  kind_o = FK_WRITE;
        else                              kind_o = FK_NONE;
    end

    assign fault_o = (kind_o != FK_NONE);
endmodule

// File: rtl/vmw_tlb.sv
module vmw_tlb #(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned TAG_W   = 20,
    parameter int unsigned DATA_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [TAG_W-1:0]  lk_tag_i,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o,
    input  logic              fill_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [DATA_W-1:0] fill_data_i
);
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][DATA_W-1:0] dat;
        logic [PTR_W-1:0]               ptr;
    } tlb_state_t;

    tlb_state_t s_d, s_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = s_q.vld[g] && (s_q.tag[g] == lk_tag_i);
    end

    assign lk_hit_o = |match;

    always_comb begin
        lk_data_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_data_o = lk_data_o | s_q.dat[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush_i) begin
            s_d.vld = '0;
        end else if (fill_i) begin
            s_d.vld[s_q.ptr] = 1'b1;
            s_d.tag[s_q.ptr] = fill_tag_i;
            s_d.dat[s_q.ptr] = fill_data_i;
            s_d.ptr          = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/vm_walker.sv
module vm_walker
    import vmw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned PAGE_OFF_W  = 12,
    parameter int unsigned TLB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic              root_we,
    input  logic [ADDR_W-1:0] root_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic [3:0]        rsp_cause,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int unsigned VPN_W  = ADDR_W - PAGE_OFF_W;
    localparam int unsigned IDX_W  = VPN_W / 2;
    localparam int unsigned SLOT_W = PAGE_OFF_W - IDX_W;
    localparam int unsigned TDAT_W = VPN_W + 2;   // {frame, user, writable}

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] va;
        logic              wr;
        logic              us;
        logic [VPN_W-1:0]  pde_pfn;
        logic              pde_w;
        logic              pde_u;
        logic              stale;
        logic [VPN_W-1:0]  root_pfn;
        logic              rsp_v;
        logic [ADDR_W-1:0] rsp_pa;
        logic              rsp_f;
        logic [3:0]        rsp_c;
    } walk_t;

    walk_t q, d;

    logic              hit;
    logic [TDAT_W-1:0] hit_data;
    logic              hit_fault;
    fault_kind_e       hit_kind;
    logic              walk_fault;
    fault_kind_e       walk_kind;
    logic              eff_w, eff_u;
    logic              fill_en;
    logic [ADDR_W-1:0] dir_addr, tbl_addr;

    assign eff_w = q.pde_w & mem_rsp_data[ENT_W];
    assign eff_u = q.pde_u & mem_rsp_data[ENT_U];

    vmw_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .TAG_W   (VPN_W),
        .DATA_W  (TDAT_W)
    ) i_tlb (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (root_we),
        .lk_tag_i    (req_vaddr[ADDR_W-1:PAGE_OFF_W]),
        .lk_hit_o    (hit),
        .lk_data_o   (hit_data),
        .fill_i      (fill_en),
        .fill_tag_i  (q.va[ADDR_W-1:PAGE_OFF_W]),
        .fill_data_i ({mem_rsp_data[ADDR_W-1:PAGE_OFF_W], eff_u, eff_w})
    );

    vmw_perm i_hit_perm (
        .present_i  (1'b1),
        .wr_ok_i    (hit_data[0]),
        .usr_ok_i   (hit_data[1]),
        .is_write_i (req_write),
        .is_user_i  (req_user),
        .fault_o    (hit_fault),
        .kind_o     (hit_kind)
    );

    vmw_perm i_walk_perm (
        .present_i  (mem_rsp_data[ENT_P]),
        .wr_ok_i    (eff_w),
        .usr_ok_i   (eff_u),
        .is_write_i (q.wr),
        .is_user_i  (q.us),
        .fault_o    (walk_fault),
        .kind_o     (walk_kind)
    );

    assign dir_addr = {q.root_pfn, q.va[ADDR_W-1 -: IDX_W], {SLOT_W{1'b0}}};
    assign tbl_addr = {q.pde_pfn, q.va[PAGE_OFF_W +: IDX_W], {SLOT_W{1'b0}}};

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        fill_en = 1'b0;
        if (root_we) d.root_pfn = root_wdata[ADDR_W-1:PAGE_OFF_W];
        case (q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.us    = req_user;
                    d.stale = 1'b0;
                    if (!paging_en) begin
                        d.rsp_v  = 1'b1;
                        d.rsp_pa = req_vaddr;
                        d.rsp_f  = 1'b0;
                        d.rsp_c  = {req_user, req_write, FK_NONE};
                    end else if (hit && !root_we) begin
                        d.rsp_v  = 1'b1;
                        d.rsp_f  = hit_fault;
                        d.rsp_pa = hit_fault ? '0 :
                                   {hit_data[TDAT_W-1:2], req_vaddr[PAGE_OFF_W-1:0]};
                        d.rsp_c  = {req_user, req_write, hit_kind};
                    end else begin
                        d.st = WS_DIR;
                    end
                end
            end
            WS_DIR: begin
                if (root_we) d.stale = 1'b1;
                if (mem_rsp_valid) begin
                    d.pde_pfn = mem_rsp_data[ADDR_W-1:PAGE_OFF_W];
                    d.pde_w   = mem_rsp_data[ENT_W];
                    d.pde_u   = mem_rsp_data[ENT_U];
                    if (!mem_rsp_data[ENT_P]) begin
                        d.rsp_v  = 1'b1;
                        d.rsp_f  = 1'b1;
                        d.rsp_pa = '0;
                        d.rsp_c  = {q.us, q.wr, FK_ABSENT};
                        d.st     = WS_IDLE;
                    end else begin
                        d.st = WS_TBL;
                    end
                end
            end
            WS_TBL: begin
                if (root_we) d.stale = 1'b1;
                if (mem_rsp_valid) begin
                    d.rsp_v  = 1'b1;
                    d.rsp_f  = walk_fault;
                    d.rsp_pa = walk_fault ? '0 :
                               {mem_rsp_data[ADDR_W-1:PAGE_OFF_W], q.va[PAGE_OFF_W-1:0]};
                    d.rsp_c  = {q.us, q.wr, walk_kind};
                    d.st     = WS_IDLE;
                    fill_en  = !walk_fault && !q.stale && !root_we;
                end
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == WS_IDLE);
    assign mem_req_valid = (q.st != WS_IDLE);
    assign mem_req_addr  = (q.st == WS_TBL) ? tbl_addr : dir_addr;
    assign rsp_valid     = q.rsp_v;
    assign rsp_paddr     = q.rsp_pa;
    assign rsp_fault     = q.rsp_f;
    assign rsp_cause     = q.rsp_c;
endmodule

// File: rtl/vm_walker_chk.sv
module vm_walker_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_OFF_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              paging_en,
    input logic              root_we,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              req_write,
    input logic              req_user,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault,
    input logic [3:0]        rsp_cause,
    input logic              mem_req_valid
);
    logic              acc;
    logic              just_acc_q, wr_q, us_q, clean_q;
    logic [ADDR_W-1:0] va_q;
    logic [2:0]        fills_q;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            just_acc_q <= 1'b0;
            wr_q       <= 1'b0;
            us_q       <= 1'b0;
            clean_q    <= 1'b0;
            va_q       <= '0;
            fills_q    <= '0;
        end else begin
            just_acc_q <= acc;
            if (acc) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                us_q    <= req_user;
                clean_q <= 1'b1;
            end else if (root_we) begin
                clean_q <= 1'b0;
            end
            if (root_we)
                fills_q <= '0;
            else if (rsp_valid && !rsp_fault && !just_acc_q && clean_q && fills_q != 3'd7)
                fills_q <= fills_q + 3'd1;
        end
    end

    AST_PASSTHRU_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !paging_en) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr))); // R1
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_OFF_W-1:0] == va_q[PAGE_OFF_W-1:0])); // R2
    AST_FETCH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R11
    AST_KIND_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause[1:0] != 2'b00))); // R6
    AST_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_cause[3:2] == {us_q, wr_q})); // R6
    AST_NO_HIT_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && paging_en && fills_q == 3'd0) |=> !rsp_valid); // R9
    AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && paging_en) |=> (rsp_valid || mem_req_valid)); // R7
endmodule

bind vm_walker vm_walker_chk #(.ADDR_W(ADDR_W), .PAGE_OFF_W(PAGE_OFF_W)) i_chk (.*);

// File: tb/test_vm_walker.sv
module test_vm_walker;
    localparam int MEM_LAT = 2;
    localparam bit [31:0] ROOT = 32'h0010_0000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic        root_we = 1'b0;
    logic [31:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [3:0]  rsp_cause;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    vm_walker #(.ADDR_W(32), .PAGE_OFF_W(12), .TLB_ENTRIES(4)) i_vm_walker (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .root_we(root_we),
        .root_wdata(root_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    bit [31:0] mem [bit [31:0]];

    // behavioural cache model: four slots, rotating fill
    bit        m_v [4];
    bit [19:0] m_vpn [4];
    bit [19:0] m_ppn [4];
    bit        m_w [4];
    bit        m_u [4];
    int        m_ptr = 0;

    function automatic bit [31:0] rd(bit [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory: answers MEM_LAT negedges after it sees a request
    bit        pend = 1'b0;
    int        cnt  = 0;
    bit [31:0] lat_addr;
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
        end
        if (pend) begin
            cnt--;
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(lat_addr);
            end
        end else if (mem_req_valid && rst_n) begin
            pend = 1'b1;
            cnt = MEM_LAT;
            lat_addr = mem_req_addr;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
    endtask

    task automatic map_page(bit [31:0] va, bit [19:0] pfn, bit [2:0] dfl, bit [2:0] tfl);
        bit [31:0] da, tb;
        da = ROOT | {20'd0, va[31:22], 2'b00};
        tb = {20'h00200 + {10'd0, va[31:22]}, 12'h000};
        mem[da] = tb | {29'd0, dfl};
        mem[tb | {20'd0, va[21:12], 2'b00}] = {pfn, 12'h000} | {29'd0, tfl};
    endtask

    task automatic write_root();
        @(negedge clk);
        root_we = 1'b1;
        root_wdata = ROOT;
        @(negedge clk);
        root_we = 1'b0;
        model_flush();
    endtask

    task automatic do_req(bit [31:0] va, bit wr, bit us, bit pg, bit mid, string rq);
        int        lat, slot;
        bit        f, walk, two, fill, ew, eu;
        bit [1:0]  k;
        bit [31:0] pa, da, ta, pde, pte;
        walk = 0; two = 0; fill = 0; slot = -1; f = 0; k = 0; pa = va; lat = 0;
        da = '0; ta = '0;
        if (pg) begin
            for (int i = 0; i < 4; i++)
                if (m_v[i] && m_vpn[i] == va[31:12]) slot = i;
            if (slot >= 0) begin
                k = (us && !m_u[slot]) ? 2'd2 : (wr && !m_w[slot]) ? 2'd3 : 2'd0;
                pa = {m_ppn[slot], va[11:0]};
            end else begin
                walk = 1;
                da = ROOT | {20'd0, va[31:22], 2'b00};
                pde = rd(da);
                if (!pde[0]) begin
                    lat = MEM_LAT + 1;
                    k = 2'd1;
                end else begin
                    two = 1;
                    ta = {pde[31:12], va[21:12], 2'b00};
                    pte = rd(ta);
                    ew = pde[1] & pte[1];
                    eu = pde[2] & pte[2];
                    lat = 2 * MEM_LAT + 2;
                    k = !pte[0] ? 2'd1 : (us && !eu) ? 2'd2 : (wr && !ew) ? 2'd3 : 2'd0;
                    pa = {pte[31:12], va[11:0]};
                end
            end
            f = (k != 2'd0);
            fill = walk && !f && !mid;
        end
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us; paging_en = pg;
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            if (mid && i == 4) begin root_we = 1'b1; root_wdata = ROOT; end
            if (mid && i == 5) root_we = 1'b0;
            chk(rsp_valid == (i == lat), rq, "rsp_valid timing", {31'd0, rsp_valid}, {31'd0, i == lat});
            chk(req_ready == (i == lat), "R11", "req_ready", {31'd0, req_ready}, {31'd0, i == lat});
            if (i == 0) begin
                chk(mem_req_valid == walk, walk ? "R3" : "R7", "fetch start",
                    {31'd0, mem_req_valid}, {31'd0, walk});
                if (walk) chk(mem_req_addr == da, "R3", "directory address", mem_req_addr, da);
            end
            if (two && i == MEM_LAT + 1)
                chk(mem_req_valid && mem_req_addr == ta, "R3", "table address", mem_req_addr, ta);
            if (!two && walk && i == lat)
                chk(!mem_req_valid, "R4", "no table fetch", {31'd0, mem_req_valid}, 32'd0);
            if (i == lat) begin
                chk(rsp_fault == f, rq, "fault", {31'd0, rsp_fault}, {31'd0, f});
                chk(rsp_cause == {us, wr, k}, rq, "cause", {28'd0, rsp_cause}, {28'd0, us, wr, k});
                if (!f) chk(rsp_paddr == pa, rq, "paddr", rsp_paddr, pa);
            end
        end
        if (mid) model_flush();
        if (fill) begin
            m_v[m_ptr] = 1'b1; m_vpn[m_ptr] = va[31:12]; m_ppn[m_ptr] = pa[31:12];
            m_w[m_ptr] = ew; m_u[m_ptr] = eu;
            m_ptr = (m_ptr + 1) % 4;
        end
    endtask

    localparam bit [31:0] VA_A = 32'h0040_1123;
    localparam bit [31:0] VA_B = 32'h0080_2000;
    localparam bit [31:0] VA_C = 32'h00C0_3000;
    localparam bit [31:0] VA_D = 32'h0040_5000;
    localparam bit [31:0] VA_E = 32'h0100_6000;

    initial begin
        model_flush();
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R11", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req_valid == 1'b0, "R11", "reset fetch", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        write_root();

        map_page(VA_A, 20'h12345, 3'b111, 3'b101);   // user, read-only
        map_page(VA_B, 20'h0ABCD, 3'b011, 3'b111);   // directory denies user
        mem[ROOT | {20'd0, VA_C[31:22], 2'b00}] = 32'h0;
        map_page(VA_D, 20'h00000, 3'b111, 3'b110);   // table entry absent
        map_page(VA_E, 20'h00777, 3'b001, 3'b001);   // kernel read-only
        for (int k = 0; k < 5; k++)
            map_page(32'h0140_0000 + (k << 12), 20'h50000 + k, 3'b111, 3'b111);

        do_req(32'hDEAD_BEEF, 1, 1, 0, 0, "R1");
        do_req(VA_A, 0, 1, 1, 0, "R2");
        do_req(VA_A, 0, 0, 1, 0, "R7");
        do_req(VA_A, 1, 1, 1, 0, "R6");
        do_req(VA_B, 0, 1, 1, 0, "R5");
        do_req(VA_B, 1, 0, 1, 0, "R8");
        do_req(VA_B, 1, 0, 1, 0, "R7");
        do_req(VA_C, 1, 1, 1, 0, "R4");
        do_req(VA_D, 0, 0, 1, 0, "R4");
        do_req(VA_E, 1, 1, 1, 0, "R6");
        do_req(VA_E, 1, 0, 1, 0, "R6");
        do_req(VA_E, 0, 0, 1, 0, "R2");
        for (int k = 0; k < 5; k++)
            do_req(32'h0140_0000 + (k << 12) + 32'h40, 0, 1, 1, 0, "R8");
        do_req(VA_A, 0, 0, 1, 0, "R8");
        do_req(32'h0140_4000, 0, 0, 1, 0, "R8");
        write_root();
        do_req(32'h0140_4000, 0, 0, 1, 0, "R9");
        do_req(VA_A, 0, 0, 1, 1, "R10");
        do_req(VA_A, 0, 0, 1, 0, "R10");
        do_req(VA_A, 1, 1, 0, 0, "R1");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule